// File: doc/BRIEF.md
# Dual-Sensor Serial Acquisition Controller

This block is one serial master that reads two peripherals sharing a clock and data line: a multi-channel 12-bit ADC and a 10-bit temperature sensor. A request is a one-cycle `go` pulse with a sensor-select bit and a 3-bit channel number. The controller drives the serial clock, the outgoing control line and one enable for each device. It shifts in the returned word and presents the decoded result together with a one-cycle `done` strobe.

The ADC needs some setup, and the controller handles it without the requester's help. Right after reset it runs two throw-away ADC frames on its own. When an ADC request names a channel other than the one last programmed, it first writes the channel into the converter's control register and then performs the read. Only the frame that carries the requested data produces `done`. A requester therefore issues `go`, waits for `done` and reads the result bus of the sensor it asked for.

Top module: `sensor_acq_ctrl`

## Requirements
- R1: While `rst_n` is low: `adc_cs_n`=1, `temp_ce`=0, `sclk`=0, `sdi`=0, `done`=0, `rst_n_out`=0, and all result buses are 0.
- R2: After reset the block runs two ADC frames by itself, with `sdi` high for all 16 bits. Neither frame produces `done`, and any `go` that arrives before both have finished is ignored.
- R3: Every frame has exactly 16 `sclk` rising edges and `sclk` idles low. The enable asserts `DIV_HALF` clocks before the first rising edge and releases `DIV_HALF` clocks after the last falling edge. Bits are MSB first: `sdi` changes after falling edges, and `sdo` is sampled at rising edges.
- R4: During a frame only the targeted device is enabled (`adc_cs_n` low for the ADC, `temp_ce` high for the sensor), and the two are never enabled together.
- R5: An ADC request is a channel change when it is the first ADC request after reset, or when its channel differs from the last channel written. A channel change runs a control-write frame and then a read frame. The control-write word has bit 15 = 1 (write enable), bits 12:10 = channel and all other bits 0. During the read frame `sdi` stays low.
- R6: An ADC request for the channel last written runs exactly one read frame, with `sdi` low.
- R7: After an ADC read, `adc_data` equals bits 11:0 of the returned word and `adc_chan` equals bits 14:12. `temp_data` is unchanged.
- R8: A temperature request runs exactly one frame to the sensor with `sdi` low and sets `temp_data` to bits 13:4 of the returned word. Its channel input is ignored: it does not change ADC channel tracking, and `adc_data`/`adc_chan` keep their values.
- R9: `done` is a single-cycle pulse, exactly one per accepted request, given one clock after the final read frame ends. It is never given for dummy or control-write frames.
- R10: A `go` that arrives while a request is in progress starts no frame and produces no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | One-cycle request pulse |
| sel_temp | input | 1 | 1 = temperature sensor, 0 = ADC |
| chan | input | 3 | ADC channel for the request |
| sdo | input | 1 | Serial data returned by the devices |
| sclk | output | 1 | Serial clock |
| rst_n_out | output | 1 | Active-low reset passed on to the devices |
| sdi | output | 1 | Serial control word to the devices |
| adc_cs_n | output | 1 | ADC select, active low |
| temp_ce | output | 1 | Temperature sensor enable, active high |
| done | output | 1 | Result-ready strobe |
| adc_data | output | 12 | Latest ADC conversion value |
| adc_chan | output | 3 | Channel reported with the ADC value |
| temp_data | output | 10 | Latest temperature code |

## Verification
The hardest case to reach is the interaction between ADC channel tracking and the other traffic. Temperature requests that carry a stray channel number, and `go` pulses that land in the middle of a frame or during the reset dummy frames, must leave no trace. The bench reaches these cases with directed sequences: a `go` during the dummy frames, a temperature request between two ADC requests for the same channel, and a second `go` partway through a frame. It then runs a seeded random mix in which the channel is biased toward repeats, so that both the write-then-read and the read-only paths occur often. A model of the serial slave in the bench records every frame (device, `sdi` word, edge count, lead and trail timing), and the bench compares that record with the frame list it expects for each request.

// File: rtl/sacq_pkg.sv
package sacq_pkg;
  localparam int unsigned WORD_BITS = 16;

  typedef enum logic [1:0] {K_DUMMY, K_CWRITE, K_READ} frame_kind_t;

  function automatic logic [WORD_BITS-1:0] ctrl_word(input logic [2:0] ch);
    logic [WORD_BITS-1:0] w;
    w = '0;
    w[15] = 1'b1;
    w[12:10] = ch;
    return w;
  endfunction

  function automatic logic [WORD_BITS-1:0] word_for(input frame_kind_t k, input logic [2:0] ch);
    case (k)
      K_DUMMY:  return '1;
      K_CWRITE: return ctrl_word(ch);
      default:  return '0;
    endcase
  endfunction

  function automatic logic [11:0] adc_value(input logic [WORD_BITS-1:0] w);
    return w[11:0];
  endfunction

  function automatic logic [2:0] adc_addr(input logic [WORD_BITS-1:0] w);
    return w[14:12];
  endfunction

  function automatic logic [9:0] temp_value(input logic [WORD_BITS-1:0] w);
    return w[13:4];
  endfunction
endpackage

// File: rtl/sacq_shifter.sv
module sacq_shifter #(
  parameter int unsigned DIV_HALF = 2,
  parameter int unsigned BITS     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            to_temp,
  input  logic [BITS-1:0] tx_word,
  input  logic            sdo,
  output logic            sclk,
  output logic            sdi,
  output logic            adc_cs_n,
  output logic            temp_ce,
  output logic            frame_end,
  output logic [BITS-1:0] rx_word
);
  localparam int unsigned PH_LAST = 2 * BITS;
  localparam int unsigned PW = $clog2(PH_LAST + 1);
  localparam int unsigned TW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic            busy_q, dev_q, sclk_q;
  logic [PW-1:0]   ph_q;
  logic [TW-1:0]   tmr_q;
  logic [BITS-1:0] tx_q, rx_q;
  logic            half_up;

  assign half_up = (tmr_q == TW'(DIV_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      dev_q     <= 1'b0;
      sclk_q    <= 1'b0;
      ph_q      <= '0;
      tmr_q     <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
      frame_end <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          dev_q  <= to_temp;
          ph_q   <= '0;
          tmr_q  <= '0;
          tx_q   <= tx_word;
          sclk_q <= 1'b0;
        end
      end else if (half_up) begin
        tmr_q <= '0;
        if (ph_q == PW'(PH_LAST)) begin
          busy_q    <= 1'b0;
          frame_end <= 1'b1;
        end else begin
          ph_q <= ph_q + 1'b1;
          if (!ph_q[0]) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[BITS-2:0], sdo};
          end else begin
            sclk_q <= 1'b0;
            tx_q   <= {tx_q[BITS-2:0], 1'b0};
          end
        end
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  assign sclk     = sclk_q;
  assign sdi      = busy_q & tx_q[BITS-1];
  assign adc_cs_n = ~(busy_q & ~dev_q);
  assign temp_ce  = busy_q & dev_q;
  assign rx_word  = rx_q;
endmodule

// File: rtl/sacq_seq.sv
module sacq_seq
  import sacq_pkg::*;
#(
  parameter int unsigned DUMMIES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic                 sel_temp,
  input  logic [2:0]           chan,
  input  logic                 frame_end,
  input  logic [WORD_BITS-1:0] rx_word,
  output logic                 frame_start,
  output logic                 frame_temp,
  output logic [WORD_BITS-1:0] tx_word,
  output logic                 done,
  output logic [11:0]          adc_data,
  output logic [2:0]           adc_chan,
  output logic [9:0]           temp_data,
  output logic                 frame_is_read,
  output logic                 dummies_pending,
  output logic                 busy
);
  localparam int unsigned DW = $clog2(DUMMIES + 1);

  frame_kind_t kind_q, go_kind;
  logic [DW-1:0] dum_q;
  logic          busy_q, temp_q, last_ok_q;
  logic [2:0]    chan_q, last_q;

  always_comb begin
    if (sel_temp)                       go_kind = K_READ;
    else if (!last_ok_q || chan != last_q) go_kind = K_CWRITE;
    else                                go_kind = K_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q      <= K_DUMMY;
      dum_q       <= DW'(DUMMIES);
      busy_q      <= 1'b0;
      temp_q      <= 1'b0;
      last_ok_q   <= 1'b0;
      chan_q      <= '0;
      last_q      <= '0;
      frame_start <= 1'b0;
      tx_word     <= '0;
      done        <= 1'b0;
      adc_data    <= '0;
      adc_chan    <= '0;
      temp_data   <= '0;
    end else begin
      frame_start <= 1'b0;
      done        <= 1'b0;
      if (!busy_q) begin
        if (dum_q != '0) begin
          busy_q      <= 1'b1;
          kind_q      <= K_DUMMY;
          temp_q      <= 1'b0;
          tx_word     <= word_for(K_DUMMY, '0);
          frame_start <= 1'b1;
        end else if (go) begin
          busy_q      <= 1'b1;
          kind_q      <= go_kind;
          temp_q      <= sel_temp;
          chan_q      <= chan;
          tx_word     <= word_for(go_kind, chan);
          frame_start <= 1'b1;
        end
      end else if (frame_end) begin
        case (kind_q)
          K_DUMMY: begin
            dum_q  <= dum_q - 1'b1;
            busy_q <= 1'b0;
          end
          K_CWRITE: begin
            last_q      <= chan_q;
            last_ok_q   <= 1'b1;
            kind_q      <= K_READ;
            tx_word     <= word_for(K_READ, chan_q);
            frame_start <= 1'b1;
          end
          default: begin
            busy_q <= 1'b0;
            done   <= 1'b1;
            if (temp_q) begin
              temp_data <= temp_value(rx_word);
            end else begin
              adc_data <= adc_value(rx_word);
              adc_chan <= adc_addr(rx_word);
            end
          end
        endcase
      end
    end
  end

  assign frame_temp      = temp_q;
  assign frame_is_read   = (kind_q == K_READ);
  assign dummies_pending = (dum_q != '0);
  assign busy            = busy_q;
endmodule

// File: rtl/sensor_acq_ctrl.sv
module sensor_acq_ctrl
  import sacq_pkg::*;
#(
  parameter int unsigned DIV_HALF = 2,
  parameter int unsigned DUMMIES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        sel_temp,
  input  logic [2:0]  chan,
  input  logic        sdo,
  output logic        sclk,
  output logic        rst_n_out,
  output logic        sdi,
  output logic        adc_cs_n,
  output logic        temp_ce,
  output logic        done,
  output logic [11:0] adc_data,
  output logic [2:0]  adc_chan,
  output logic [9:0]  temp_data
);
  logic                 frame_start, frame_temp, frame_end;
  logic                 frame_is_read, dummies_pending, seq_busy;
  logic [WORD_BITS-1:0] tx_word, rx_word;
  logic                 rst_out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_out_q <= 1'b0;
    else        rst_out_q <= 1'b1;
  end
  assign rst_n_out = rst_out_q;

  sacq_seq #(.DUMMIES(DUMMIES)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .sel_temp(sel_temp), .chan(chan),
    .frame_end(frame_end), .rx_word(rx_word),
    .frame_start(frame_start), .frame_temp(frame_temp), .tx_word(tx_word),
    .done(done), .adc_data(adc_data), .adc_chan(adc_chan), .temp_data(temp_data),
    .frame_is_read(frame_is_read), .dummies_pending(dummies_pending), .busy(seq_busy)
  );

  sacq_shifter #(.DIV_HALF(DIV_HALF), .BITS(WORD_BITS)) u_shf (
    .clk(clk), .rst_n(rst_n), .start(frame_start), .to_temp(frame_temp),
    .tx_word(tx_word), .sdo(sdo), .sclk(sclk), .sdi(sdi),
    .adc_cs_n(adc_cs_n), .temp_ce(temp_ce), .frame_end(frame_end), .rx_word(rx_word)
  );
endmodule

// File: rtl/sacq_checker.sv
module sacq_checker (
  input logic clk,
  input logic rst_n,
  input logic rst_n_out,
  input logic sclk,
  input logic sdi,
  input logic adc_cs_n,
  input logic temp_ce,
  input logic done,
  input logic frame_end,
  input logic frame_is_read,
  input logic dummies_pending
);
  always_comb begin
    if (!rst_n) begin
      assert_rst_out_low_R1: assert (!rst_n_out);
    end
  end

  assert_one_device_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!adc_cs_n && temp_ce));

  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_cs_n && !temp_ce) |-> !sclk);

  assert_sdi_quiet_temp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    temp_ce |-> !sdi);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_done_internal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_is_read) |=> !done);

  assert_no_done_dummy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dummies_pending |-> !done);

  assert_done_after_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (adc_cs_n && !temp_ce));
endmodule

bind sensor_acq_ctrl sacq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rst_n_out(rst_n_out), .sclk(sclk), .sdi(sdi),
  .adc_cs_n(adc_cs_n), .temp_ce(temp_ce), .done(done), .frame_end(frame_end),
  .frame_is_read(frame_is_read), .dummies_pending(dummies_pending)
);

// File: tb/sensor_acq_ctrl_test.sv
module sensor_acq_ctrl_test;
  localparam int DIVH = 2;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, sel_temp = 1'b0, sdo;
  logic [2:0] chan = '0;
  logic sclk, rst_n_out, sdi, adc_cs_n, temp_ce, done;
  logic [11:0] adc_data;
  logic [2:0]  adc_chan;
  logic [9:0]  temp_data;

  always #4 clk = ~clk;

  sensor_acq_ctrl #(.DIV_HALF(DIVH)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .sel_temp(sel_temp), .chan(chan), .sdo(sdo),
    .sclk(sclk), .rst_n_out(rst_n_out), .sdi(sdi), .adc_cs_n(adc_cs_n),
    .temp_ce(temp_ce), .done(done), .adc_data(adc_data), .adc_chan(adc_chan),
    .temp_data(temp_data)
  );

  int total = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model and frame recorder
  logic [15:0] adc_word = '0, temp_word = '0;
  int nr = 16, cyc = 0, t_cs = 0, t_first = 0, t_last = 0, nf = 0, ndone = 0;
  logic cs_prev = 1'b0, sclk_prev = 1'b0, cur_dev = 1'b0;
  logic [15:0] cap = '0;
  logic        fdev   [512];
  logic [15:0] fword  [512];
  int          frises [512];
  int          flead  [512];
  int          ftrail [512];
  wire cs_any = !adc_cs_n || temp_ce;

  always_comb begin
    if (nr < 16) sdo = temp_ce ? temp_word[15-nr] : adc_word[15-nr];
    else         sdo = 1'b0;
  end

  always @(negedge clk) begin
    cyc++;
    if (done) ndone++;
    if (cs_any && !cs_prev) begin
      t_cs = cyc; nr = 0; cap = '0; cur_dev = temp_ce;
    end
    if (sclk && !sclk_prev) begin
      if (nr == 0) t_first = cyc;
      cap = {cap[14:0], sdi};
      nr++;
    end
    if (!sclk && sclk_prev) t_last = cyc;
    if (!cs_any && cs_prev && nf < 512) begin
      fdev[nf] = cur_dev; fword[nf] = cap; frises[nf] = nr;
      flead[nf] = t_first - t_cs; ftrail[nf] = cyc - t_last;
      nf++;
    end
    cs_prev = cs_any; sclk_prev = sclk;
  end

  function automatic logic [15:0] exp_ctrl(input logic [2:0] c);
    return 16'h8000 + ({13'd0, c} * 16'd1024);
  endfunction

  function automatic logic [9:0] exp_temp(input logic [15:0] w);
    return 10'((w >> 4) & 16'h03ff);
  endfunction

  // bench model of channel tracking and results
  logic       m_ok = 1'b0;
  logic [2:0] m_last = '0;
  logic [11:0] e_adc = '0;
  logic [2:0]  e_ach = '0;
  logic [9:0]  e_tmp = '0;

  task automatic pulse_go(input bit t, input logic [2:0] c);
    @(negedge clk); go = 1'b1; sel_temp = t; chan = c;
    @(negedge clk); go = 1'b0; chan = $urandom;
  endtask

  task automatic check_frame(input int i, input bit dev, input logic [15:0] w, input string req);
    chk(fdev[i] == dev, {req, " frame device"}, fdev[i], dev);
    chk(fword[i] == w, {req, " frame sdi word"}, fword[i], w);
    chk(frises[i] == 16, "R3 rising edges", frises[i], 16);
    chk(flead[i] == DIVH && ftrail[i] == DIVH, "R3 lead/trail", flead[i]*256 + ftrail[i], DIVH*257);
  endtask

  task automatic do_req(input bit t, input logic [2:0] c, input bit late_go);
    int nf0, d0, n;
    bit change;
    logic [2:0] rc;
    logic [11:0] rv;
    rc = $urandom; rv = $urandom;
    adc_word = {1'b0, rc, rv};
    temp_word = $urandom;
    nf0 = nf; d0 = ndone;
    change = !t && (!m_ok || c != m_last);
    pulse_go(t, c);
    if (late_go) begin
      repeat (10) @(negedge clk);
      pulse_go(!t, c + 3'd1);
    end
    n = 0;
    while (ndone == d0 && n < 3000) begin @(negedge clk); n++; end
    repeat (late_go ? 250 : 3) @(negedge clk);
    chk(ndone - d0 == 1, "R9 one done per request", ndone - d0, 1);
    if (t) begin
      chk(nf - nf0 == 1, late_go ? "R10 frame count" : "R8 frame count", nf - nf0, 1);
      check_frame(nf0, 1'b1, 16'h0000, "R8");
      e_tmp = exp_temp(temp_word);
    end else if (change) begin
      chk(nf - nf0 == 2, "R5 frame count", nf - nf0, 2);
      check_frame(nf0, 1'b0, exp_ctrl(c), "R5");
      check_frame(nf0 + 1, 1'b0, 16'h0000, "R5");
      m_ok = 1'b1; m_last = c;
      e_adc = rv; e_ach = rc;
    end else begin
      chk(nf - nf0 == 1, late_go ? "R10 frame count" : "R6 frame count", nf - nf0, 1);
      check_frame(nf0, 1'b0, 16'h0000, "R6");
      e_adc = rv; e_ach = rc;
    end
    chk(adc_data == e_adc, "R7 adc_data", adc_data, e_adc);
    chk(adc_chan == e_ach, "R7 adc_chan", adc_chan, e_ach);
    chk(temp_data == e_tmp, "R8 temp_data", temp_data, e_tmp);
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(adc_cs_n && !temp_ce && !sclk && !sdi && !done, "R1 idle pins",
        {adc_cs_n, temp_ce, sclk, sdi, done}, 5'b10000);
    chk(!rst_n_out, "R1 rst_n_out", rst_n_out, 0);
    chk(adc_data == 0 && adc_chan == 0 && temp_data == 0, "R1 results",
        {adc_data, adc_chan, temp_data}, 0);
    rst_n = 1'b1;
    // R2: dummies run alone; go meanwhile is ignored
    repeat (20) @(negedge clk);
    pulse_go(1'b1, 3'd2);
    begin
      int n = 0;
      while (nf < 2 && n < 2000) begin @(negedge clk); n++; end
    end
    repeat (200) @(negedge clk);
    chk(nf == 2, "R2 dummy frame count", nf, 2);
    chk(ndone == 0, "R2 no done", ndone, 0);
    chk(rst_n_out, "R1 rst_n_out released", rst_n_out, 1);
    check_frame(0, 1'b0, 16'hffff, "R2");
    check_frame(1, 1'b0, 16'hffff, "R2");
    // directed corners
    do_req(1'b0, 3'd3, 1'b0);   // first ADC request: write + read
    do_req(1'b0, 3'd3, 1'b0);   // same channel
    do_req(1'b1, 3'd5, 1'b0);   // temperature, stray channel
    do_req(1'b0, 3'd3, 1'b0);   // still no write needed
    do_req(1'b0, 3'd0, 1'b0);   // change
    do_req(1'b0, 3'd0, 1'b1);   // R10: go mid-frame
    do_req(1'b1, 3'd7, 1'b1);   // R10 on temperature
    // random mix
    for (int i = 0; i < 40; i++) begin
      bit t;
      logic [2:0] c;
      t = ($urandom % 3) == 0;
      c = (($urandom % 2) == 0) ? m_last : 3'($urandom);
      do_req(t, c, 1'b0);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule